// File: doc/BRIEF.md
# Dual-Mode Memory Address and Byte-Lane Bridge

This block sits between an 8-bit processor data bus and a memory that is 16 bits wide in both address and word. It owns two 8-bit page registers, a high address byte and a low address byte, which the processor loads from the bus. On every cycle it picks one of three address sources and presents that address to an internal memory model. In the fetch phase the source is the program counter. In the execute phase there are two data modes. One joins the high and low registers. The other joins the high register with the immediate byte of the current instruction.

During execute, one of four one-hot selects chooses the access. The low byte or the high byte of the addressed word can be driven onto the bus, or a bus byte can be written into either lane. The lane that is not written keeps its contents. The memory has a synchronous write and a combinational read. The whole word at the current address is always presented on its own output, so the processor can capture its instruction and immediate bytes during fetch. The program counter, the phase signal and the decoded selects all come from outside.

Top module: `membus_bridge`

## Requirements
- R1: While `rst_n` is low, both page registers are cleared to zero. They stay cleared until a load occurs after reset is released, so an execute cycle in pair mode then addresses 0x0000.
- R2: While `fetch_i` is 1, `mem_addr_o` equals `pc_i` whatever the mode and register state. In every cycle `mem_word_o` shows the stored word at the current address.
- R3: In execute with `addr_mode_i` = 0 (pair mode), `mem_addr_o` = {high register, low register}.
- R4: In execute with `addr_mode_i` = 1 (page mode), `mem_addr_o` = {high register, `imm_i`}.
- R5: At a clock edge in execute, `ld_hi_i` loads `bus_i` into the high register and `ld_lo_i` loads it into the low register. Loads asserted during fetch are ignored, and a register keeps its value when it is not loaded. The address used in a cycle is the address from before that cycle's load.
- R6: In execute with `rd_lo_i` = 1, `bus_o` = bits 7:0 of the addressed word and `bus_oe_o` = 1.
- R7: In execute with `rd_hi_i` = 1, `bus_o` = bits 15:8 of the addressed word and `bus_oe_o` = 1.
- R8: When no read select is active, or during fetch, `bus_oe_o` = 0 and `bus_o` = 0. The four selects {`rd_lo_i`, `rd_hi_i`, `wr_lo_i`, `wr_hi_i`} have at most one bit set.
- R9: In execute, `wr_lo_i` writes `bus_i` into bits 7:0 of the addressed word at the clock edge, and bits 15:8 are left unchanged.
- R10: In execute, `wr_hi_i` writes `bus_i` into bits 15:8 of the addressed word at the clock edge, and bits 7:0 are left unchanged.
- R11: Write selects asserted during fetch change no stored word.
- R12: The memory model has 2^`MEM_AW` words and uses only address bits `MEM_AW`-1:0, so addresses that differ only above those bits reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_i | input | 1 | 1 = fetch phase, 0 = execute phase |
| pc_i | input | 16 | Program counter address used in fetch |
| addr_mode_i | input | 1 | 0 = pair mode, 1 = page-plus-immediate mode |
| imm_i | input | 8 | Immediate byte of the current instruction |
| ld_hi_i | input | 1 | Load high page register from bus |
| ld_lo_i | input | 1 | Load low page register from bus |
| rd_lo_i | input | 1 | Drive low byte of word onto bus |
| rd_hi_i | input | 1 | Drive high byte of word onto bus |
| wr_lo_i | input | 1 | Write bus byte into low byte of word |
| wr_hi_i | input | 1 | Write bus byte into high byte of word |
| bus_i | input | 8 | Byte arriving from the main bus |
| bus_o | output | 8 | Byte read from memory, zero when not driving |
| bus_oe_o | output | 1 | Bus drive enable |
| mem_addr_o | output | 16 | Selected memory address |
| mem_word_o | output | 16 | Word stored at the selected address |

## Verification
The bench builds the block with an 8-bit byte and `MEM_AW` = 6, so the model holds 64 words. Random 16-bit program counters and {page, immediate} pairs then fold onto the same few words again and again. This places reads after writes of the other lane, aliased addresses and fetch-phase write attempts on the same word within a short run. It also makes it practical to write every word at the start, so that all later reads are checked against known contents.

// File: rtl/membus_pkg.sv
package membus_pkg;
  // Two byte lanes per memory word: lane 0 = low byte, lane 1 = high byte.
  localparam int LANES = 2;

  typedef enum logic [1:0] {
    SRC_PC   = 2'd0,
    SRC_PAIR = 2'd1,
    SRC_PAGE = 2'd2
  } addr_src_e;
endpackage

// File: rtl/membus_rst_sync.sv
module membus_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sn_o = sync_q[1];
endmodule

// File: rtl/membus_page_regs.sv
module membus_page_regs #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              exec_i,
  input  logic              ld_hi_i,
  input  logic              ld_lo_i,
  input  logic [BYTE_W-1:0] bus_i,
  output logic [BYTE_W-1:0] hi_o,
  output logic [BYTE_W-1:0] lo_o
);
  logic              hi_en, lo_en;
  logic [BYTE_W-1:0] hi_d, lo_d;
  logic [BYTE_W-1:0] hi_q, lo_q;

  // next-state: loads only take effect on an execute edge
  always_comb begin
    hi_en = exec_i && ld_hi_i;
    lo_en = exec_i && ld_lo_i;
    hi_d  = bus_i;
    lo_d  = bus_i;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hi_en) hi_q <= hi_d;
      if (lo_en) lo_q <= lo_d;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  assert_hi_load_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (exec_i && ld_hi_i) |=> (hi_o == $past(bus_i)));
  assert_lo_load_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (exec_i && ld_lo_i) |=> (lo_o == $past(bus_i)));
  assert_hi_hold_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    !(exec_i && ld_hi_i) |=> $stable(hi_o));
  assert_lo_hold_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    !(exec_i && ld_lo_i) |=> $stable(lo_o));
endmodule

// File: rtl/membus_addr_sel.sv
module membus_addr_sel
  import membus_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input  logic              fetch_i,
  input  logic              mode_page_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [BYTE_W-1:0] hi_i,
  input  logic [BYTE_W-1:0] lo_i,
  input  logic [BYTE_W-1:0] imm_i,
  output logic [ADDR_W-1:0] addr_o
);
  addr_src_e src;

  always_comb begin
    if (fetch_i)          src = SRC_PC;
    else if (mode_page_i) src = SRC_PAGE;
    else                  src = SRC_PAIR;
  end

  always_comb begin
    unique case (src)
      SRC_PAIR: addr_o = {hi_i, lo_i};
      SRC_PAGE: addr_o = {hi_i, imm_i};
      default:  addr_o = pc_i;
    endcase
  end
endmodule

// File: rtl/membus_lane_io.sv
module membus_lane_io
  import membus_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              exec_i,
  input  logic [LANES-1:0]  rd_sel_i,
  input  logic [LANES-1:0]  wr_sel_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [BYTE_W-1:0] bus_i,
  output logic [BYTE_W-1:0] bus_o,
  output logic              oe_o,
  output logic [LANES-1:0]  we_o,
  output logic [WORD_W-1:0] wdata_o
);
  logic [LANES-1:0][BYTE_W-1:0] pick;
  logic [LANES-1:0]             rd_act;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign rd_act[k] = exec_i && rd_sel_i[k];
    assign pick[k]   = rd_act[k] ? word_i[k*BYTE_W +: BYTE_W] : '0;
    assign we_o[k]   = exec_i && wr_sel_i[k];
    assign wdata_o[k*BYTE_W +: BYTE_W] = bus_i;
  end

  always_comb begin
    bus_o = '0;
    for (int k = 0; k < LANES; k++) bus_o = bus_o | pick[k];
  end

  assign oe_o = |rd_act;

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    !oe_o |-> (bus_o == '0));
  assert_oe_exec_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    oe_o |-> (exec_i && (rd_sel_i != '0)));
endmodule

// File: rtl/membus_mem.sv
module membus_mem
  import membus_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int MEM_AW = 8,
  localparam int WORD_W = LANES * BYTE_W,
  localparam int DEPTH  = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic [MEM_AW-1:0] idx_i,
  input  logic [LANES-1:0]  we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] arr [DEPTH];

  for (genvar k = 0; k < LANES; k++) begin : g_wr
    always_ff @(posedge clk) begin
      if (we_i[k]) arr[idx_i][k*BYTE_W +: BYTE_W] <= wdata_i[k*BYTE_W +: BYTE_W];
    end

    // R9 (lane 0) and R10 (lane 1): the written lane takes the bus byte
    assert_lane_write_R9: assert property (@(posedge clk) disable iff (!rst_sn)
      we_i[k] |=> (arr[$past(idx_i)][k*BYTE_W +: BYTE_W] ==
                   $past(wdata_i[k*BYTE_W +: BYTE_W])));
    // R9, R10: a lane that is not written keeps its byte
    assert_lane_keep_R10: assert property (@(posedge clk) disable iff (!rst_sn)
      !we_i[k] |=> (arr[$past(idx_i)][k*BYTE_W +: BYTE_W] ===
                    $past(arr[idx_i][k*BYTE_W +: BYTE_W])));
  end

  assign rdata_o = arr[idx_i];

  assert_we_onehot_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0(we_i));
endmodule

// File: rtl/membus_bridge.sv
module membus_bridge
  import membus_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int MEM_AW = 8,
  localparam int ADDR_W = 2 * BYTE_W,
  localparam int WORD_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              addr_mode_i,
  input  logic [BYTE_W-1:0] imm_i,
  input  logic              ld_hi_i,
  input  logic              ld_lo_i,
  input  logic              rd_lo_i,
  input  logic              rd_hi_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] bus_i,
  output logic [BYTE_W-1:0] bus_o,
  output logic              bus_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_word_o
);
  logic              rst_sn;
  logic              exec;
  logic [BYTE_W-1:0] hi_reg, lo_reg;
  logic [LANES-1:0]  rd_sel, wr_sel, we;
  logic [WORD_W-1:0] wdata;

  assign exec   = !fetch_i;
  assign rd_sel = {rd_hi_i, rd_lo_i};
  assign wr_sel = {wr_hi_i, wr_lo_i};

  membus_rst_sync u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_sn_o (rst_sn)
  );

  membus_page_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .exec_i  (exec),
    .ld_hi_i (ld_hi_i),
    .ld_lo_i (ld_lo_i),
    .bus_i   (bus_i),
    .hi_o    (hi_reg),
    .lo_o    (lo_reg)
  );

  membus_addr_sel #(.BYTE_W(BYTE_W)) u_asel (
    .fetch_i     (fetch_i),
    .mode_page_i (addr_mode_i),
    .pc_i        (pc_i),
    .hi_i        (hi_reg),
    .lo_i        (lo_reg),
    .imm_i       (imm_i),
    .addr_o      (mem_addr_o)
  );

  membus_lane_io #(.BYTE_W(BYTE_W)) u_lane (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .exec_i   (exec),
    .rd_sel_i (rd_sel),
    .wr_sel_i (wr_sel),
    .word_i   (mem_word_o),
    .bus_i    (bus_i),
    .bus_o    (bus_o),
    .oe_o     (bus_oe_o),
    .we_o     (we),
    .wdata_o  (wdata)
  );

  membus_mem #(.BYTE_W(BYTE_W), .MEM_AW(MEM_AW)) u_mem (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .idx_i   (mem_addr_o[MEM_AW-1:0]),
    .we_i    (we),
    .wdata_i (wdata),
    .rdata_o (mem_word_o)
  );

  assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0({rd_lo_i, rd_hi_i, wr_lo_i, wr_hi_i}));
  assert_fetch_quiet_R11: assert property (@(posedge clk) disable iff (!rst_sn)
    fetch_i |-> (!bus_oe_o && (we == '0)));
  assert_fetch_pc_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    fetch_i |-> (mem_addr_o == pc_i));
endmodule

// File: tb/membus_bridge_test.sv
module membus_bridge_test;
  localparam int BW  = 8;
  localparam int MAW = 6;
  localparam int NW  = 1 << MAW;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_i, addr_mode_i, ld_hi_i, ld_lo_i;
  logic        rd_lo_i, rd_hi_i, wr_lo_i, wr_hi_i;
  logic [15:0] pc_i;
  logic [7:0]  imm_i, bus_i, bus_o;
  logic        bus_oe_o;
  logic [15:0] mem_addr_o, mem_word_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  bit inited = 0;

  logic [15:0] mdl [NW];
  logic [7:0]  m_hi, m_lo;

  always #10 clk = ~clk;

  membus_bridge #(.BYTE_W(BW), .MEM_AW(MAW)) uut (
    .clk(clk), .rst_n(rst_n), .fetch_i(fetch_i), .pc_i(pc_i),
    .addr_mode_i(addr_mode_i), .imm_i(imm_i), .ld_hi_i(ld_hi_i), .ld_lo_i(ld_lo_i),
    .rd_lo_i(rd_lo_i), .rd_hi_i(rd_hi_i), .wr_lo_i(wr_lo_i), .wr_hi_i(wr_hi_i),
    .bus_i(bus_i), .bus_o(bus_o), .bus_oe_o(bus_oe_o),
    .mem_addr_o(mem_addr_o), .mem_word_o(mem_word_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_addr(input logic f, input logic [15:0] pc,
                                           input logic md, input logic [7:0] im);
    if (f) return pc;
    if (md) return {m_hi, im};
    return {m_hi, m_lo};
  endfunction

  // sel bits: [0] read low, [1] read high, [2] write low, [3] write high
  task automatic step(input logic f, input logic [15:0] pc, input logic md,
                      input logic [7:0] im, input logic lh, input logic ll,
                      input logic [7:0] b, input logic [3:0] sel);
    logic [15:0] ea;
    logic [15:0] w;
    logic [7:0]  eb;
    logic        eo;
    int          ix;
    @(negedge clk);
    fetch_i = f; pc_i = pc; addr_mode_i = md; imm_i = im;
    ld_hi_i = lh; ld_lo_i = ll; bus_i = b;
    rd_lo_i = sel[0]; rd_hi_i = sel[1]; wr_lo_i = sel[2]; wr_hi_i = sel[3];
    #4;
    ea = exp_addr(f, pc, md, im);
    ix = int'(ea[MAW-1:0]);
    if (f)       chk("R2 fetch address is pc", mem_addr_o, ea);
    else if (md) chk("R4 page address (R5 high reg)", mem_addr_o, ea);
    else         chk("R3 pair address (R5 regs)", mem_addr_o, ea);
    eo = !f && (sel[0] || sel[1]);
    w  = mdl[ix];
    eb = !eo ? 8'h00 : (sel[0] ? w[7:0] : w[15:8]);
    chk("R8 bus drive enable", {15'd0, bus_oe_o}, {15'd0, eo});
    if (inited) begin
      chk("R2 word at address (R9 R10 R11 R12 stored data)", mem_word_o, w);
      if (!eo)         chk("R8 idle bus is zero", {8'd0, bus_o}, {8'd0, eb});
      else if (sel[0]) chk("R6 low byte read", {8'd0, bus_o}, {8'd0, eb});
      else             chk("R7 high byte read", {8'd0, bus_o}, {8'd0, eb});
    end
    @(posedge clk);
    #1;
    if (!f) begin
      if (sel[2]) mdl[ix][7:0]  = b;
      if (sel[3]) mdl[ix][15:8] = b;
      if (lh) m_hi = b;
      if (ll) m_lo = b;
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    m_hi = 8'h00; m_lo = 8'h00;
    fetch_i = 1'b0; pc_i = '0; addr_mode_i = 1'b0; imm_i = '0;
    ld_hi_i = 1'b0; ld_lo_i = 1'b0; bus_i = '0;
    rd_lo_i = 1'b0; rd_hi_i = 1'b0; wr_lo_i = 1'b0; wr_hi_i = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: registers cleared -> pair-mode address is zero
    @(negedge clk); #4;
    chk("R1 reset pair address", mem_addr_o, 16'h0000);
    chk("R1 reset bus idle", {15'd0, bus_oe_o}, 16'd0);

    // fill every word through page mode, both lanes
    for (int i = 0; i < NW; i++) begin
      step(1'b0, 16'h0, 1'b1, 8'(i), 1'b0, 1'b0, 8'($urandom), 4'b0100);
      step(1'b0, 16'h0, 1'b1, 8'(i), 1'b0, 1'b0, 8'($urandom), 4'b1000);
    end
    inited = 1;

    // R9: low write keeps high byte, R10: high write keeps low byte
    step(1'b0, 16'h0, 1'b1, 8'h05, 1'b0, 1'b0, 8'hA1, 4'b0100);
    step(1'b0, 16'h0, 1'b1, 8'h05, 1'b0, 1'b0, 8'h00, 4'b0010);
    step(1'b0, 16'h0, 1'b1, 8'h05, 1'b0, 1'b0, 8'hB2, 4'b1000);
    step(1'b0, 16'h0, 1'b1, 8'h05, 1'b0, 1'b0, 8'h00, 4'b0001);
    // R11: writes during fetch ignored; R8: reads during fetch do not drive
    step(1'b1, 16'hFF05, 1'b0, 8'h00, 1'b0, 1'b0, 8'h3C, 4'b0100);
    step(1'b1, 16'h0005, 1'b0, 8'h00, 1'b0, 1'b0, 8'h3D, 4'b1000);
    step(1'b1, 16'h0005, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 4'b0001);
    step(1'b0, 16'h0, 1'b1, 8'h05, 1'b0, 1'b0, 8'h00, 4'b0001);
    step(1'b0, 16'h0, 1'b1, 8'h05, 1'b0, 1'b0, 8'h00, 4'b0010);
    // R5: loads in fetch ignored, then loads in execute, address before load
    step(1'b1, 16'h1234, 1'b0, 8'h00, 1'b1, 1'b1, 8'hEE, 4'b0000);
    step(1'b0, 16'h0, 1'b0, 8'h00, 1'b1, 1'b0, 8'hC3, 4'b0000);
    step(1'b0, 16'h0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h47, 4'b0100);
    step(1'b0, 16'h0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h5A, 4'b0100);
    // R12: {C3,47} aliases word 7
    step(1'b0, 16'h0, 1'b1, 8'h07, 1'b0, 1'b0, 8'h00, 4'b0001);
    step(1'b1, 16'h8007, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 4'b0000);

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] s;
      int r;
      r = int'($urandom % 5);
      s = (r == 0) ? 4'b0000 : 4'(1 << (r - 1));
      step(($urandom % 4) == 0, 16'($urandom), 1'($urandom), 8'($urandom),
           ($urandom % 6) == 0, ($urandom % 6) == 0, 8'($urandom), s);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule